// File: doc/BRIEF.md
# Message Checksum Generator and Checker

This block computes a 16-bit running checksum over the data words of one data-bus message. It sits beside the word path of a remote terminal. When the terminal transmits, the block overwrites the word in the final slot of the message with the checksum, so the message length does not change. When the terminal receives, it checks that the final word closes the accumulation to zero. It then reports a pass flag and, if so configured, a flag that tells the terminal to set a status bit and keep the data from the subsystem.

Each word is added to the accumulator modulo 2^16, and the sum is then rotated left by one bit. The checksum is the two's complement of the accumulator just before the final word, so a correct message leaves the accumulator at zero. The message frame is opened by a start strobe. The final slot is the word whose index equals the announced total minus one. An end strobe closes a message early, and no verdict is given for it. The active-low enable, the direction and the reject control are sampled with the start strobe and held for the whole message.

Top module: `msg_checksum_unit`

## Requirements
- R1: While `chk_en_n` was high at the start strobe, every word of that message appears unchanged on `tx_word`, and `verdict_vld`, `sum_good` and `reject_data` stay low after its final word.
- R2: The accumulator is cleared by `som`. Each accepted word is added modulo 2^16 and the sum is then rotated left by one bit (bit 15 moves to bit 0).
- R3: On a transmit message (`dir_tx` = 1) with checking enabled, the word whose index equals `wd_total` − 1 is replaced on `tx_word`, in the same cycle, by the two's complement of the accumulator at that point. All other words pass unchanged.
- R4: On an enabled receive message, `verdict_vld` rises one clock after the final word strobe. `sum_good` is high in that cycle exactly when the accumulation, including the final word, is zero. On transmit, `verdict_vld` rises with `sum_good` low.
- R5: `reject_data` rises with the verdict only on an enabled receive message whose checksum failed while `illeg_tie` was high at the start strobe. It is never high together with `sum_good`.
- R6: A one-word message (`wd_total` = 1) is a checksum-only message. Its checksum is 0000h: on transmit the word is replaced by 0000h, and on receive it passes only if the word is 0000h.
- R7: Word strobes that arrive while no message is open (before `som`, after the final word, or after `eom`) change neither the flags nor the accumulator, and they pass through `tx_word` unchanged.
- R8: An `eom` strobe before the final word closes the message with no verdict, so the flags stay low.
- R9: After a clock edge with `rst_n` low, all three flags are low.
- R10: The flags hold their value until the next `som`, which clears them unless the final word of a one-word message arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| som | input | 1 | Start-of-message strobe; samples controls, clears accumulator and flags |
| eom | input | 1 | End-of-message strobe; closes an open message |
| dir_tx | input | 1 | Direction sampled at `som`: 1 = transmit, 0 = receive |
| chk_en_n | input | 1 | Checksum enable, active low, sampled at `som` |
| illeg_tie | input | 1 | When high at `som`, a failed receive checksum raises `reject_data` |
| wd_stb | input | 1 | Word strobe |
| wd_data | input | 16 | Word presented with the strobe |
| wd_idx | input | 5 | Position of the word within the message, from 0 |
| wd_total | input | 6 | Number of words in the message, 1 to 32 |
| tx_word | output | 16 | Word after checksum substitution (combinational) |
| verdict_vld | output | 1 | A checksum verdict is held for the current message |
| sum_good | output | 1 | Received checksum correct |
| reject_data | output | 1 | Withhold data and set the chosen status bit |

## Verification
The hardest case to reach is a stray word that carries the final-slot index and arrives after a message has already closed. A block that does not track the frame would evaluate such a word again and overwrite a held verdict. The stimulus completes a passing receive message and then strobes words with the final index and nonzero data, without a new start strobe. It then confirms that both the held pass verdict and the passed-through words are unchanged. Received messages that pass are built with their closing word computed by an independent model of the rotate-and-add rule, so that pass and fail outcomes, with and without the reject control, can be placed on chosen words.

// File: rtl/msg_cs_pkg.sv
// Package: shared types for the message checksum unit.
// Assumes: a single clock domain and a 1-bit direction encoding.
package msg_cs_pkg;

    // Direction of the message, sampled at start of message.
    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } dir_e;

    // Held checksum verdict of one message.
    typedef struct packed {
        logic vld;
        logic good;
        logic rej;
    } verdict_t;

endpackage

// File: rtl/msg_cs_frame.sv
// Module: msg_cs_frame
// Tracks whether a message is open, accepts words only inside a message,
// detects the final slot and holds the per-message controls sampled at som.
// Assumes: wd_total is in 1..2**IDX_W. A total of zero never gives a final slot.
module msg_cs_frame
    import msg_cs_pkg::*;
#(
    parameter int IDX_W = 5,
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             som,
    input  logic             eom,
    input  logic             dir_tx,
    input  logic             chk_en_n,
    input  logic             illeg_tie,
    input  logic             wd_stb,
    input  logic [IDX_W-1:0] wd_idx,
    input  logic [CNT_W-1:0] wd_total,
    output logic             acpt,
    output logic             is_last,
    output logic             en_cur,
    output logic             tx_mode,
    output logic             ill_cur
);

    logic open_r;
    logic en_r;
    logic ill_r;
    dir_e dir_r;
    dir_e dir_cur;
    logic closing;

    // Pick the live controls: straight from the pins on som, else the held copy.
    always_comb begin
        en_cur  = som ? !chk_en_n : en_r;
        ill_cur = som ? illeg_tie : ill_r;
        dir_cur = som ? dir_e'(dir_tx) : dir_r;
        tx_mode = (dir_cur == DIR_TX);
    end

    // Qualify the word strobe and decode the final slot.
    always_comb begin
        acpt    = wd_stb && (som || open_r);
        is_last = ({1'b0, wd_idx} + CNT_W'(1)) == wd_total;
        closing = acpt && is_last;
    end

    // Hold the frame state and the per-message controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_r <= 1'b0;
            en_r   <= 1'b0;
            ill_r  <= 1'b0;
            dir_r  <= DIR_RX;
        end else begin
            if (som) begin
                open_r <= !closing;
                en_r   <= !chk_en_n;
                ill_r  <= illeg_tie;
                dir_r  <= dir_e'(dir_tx);
            end else if (closing || eom) begin
                open_r <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/msg_cs_accum.sv
// Module: msg_cs_accum
// Running checksum accumulator: add modulo 2**WORD_W, then rotate left by one.
// Assumes: clear (start of message) and a word may arrive in the same cycle;
// the word then adds to an accumulator of zero.
module msg_cs_accum #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              acpt,
    input  logic [WORD_W-1:0] word_eff,
    output logic [WORD_W-1:0] acc_base,
    output logic [WORD_W-1:0] acc_final
);

    logic [WORD_W-1:0] acc_r;
    logic [WORD_W-1:0] sum;
    logic [WORD_W-1:0] rot;

    // Start from zero when the message starts in this cycle.
    always_comb begin
        acc_base = clear ? '0 : acc_r;
        sum      = acc_base + word_eff;
    end

    // Wire a left rotation by one bit, one assignment per bit.
    for (genvar b = 0; b < WORD_W; b++) begin : g_rot
        assign rot[b] = sum[(b + WORD_W - 1) % WORD_W];
    end

    assign acc_final = rot;

    // Update the accumulator on each accepted word, clear it on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_r <= '0;
        end else if (acpt) begin
            acc_r <= acc_final;
        end else if (clear) begin
            acc_r <= '0;
        end
    end

endmodule

// File: rtl/msg_cs_slot.sv
// Module: msg_cs_slot
// Substitutes the checksum into the final slot of a transmit message.
// Assumes: acc_base already reflects every earlier word of the message.
module msg_cs_slot #(
    parameter int WORD_W = 16
) (
    input  logic              en_cur,
    input  logic              tx_mode,
    input  logic              acpt,
    input  logic              is_last,
    input  logic [WORD_W-1:0] wd_data,
    input  logic [WORD_W-1:0] acc_base,
    output logic [WORD_W-1:0] tx_word
);

    logic              subst;
    logic [WORD_W-1:0] cksum;

    // Choose the checksum that drives the final sum to zero, and decide when to use it.
    always_comb begin
        cksum   = '0 - acc_base;
        subst   = en_cur && tx_mode && acpt && is_last;
        tx_word = subst ? cksum : wd_data;
    end

endmodule

// File: rtl/msg_cs_verdict.sv
// Module: msg_cs_verdict
// Registers the checksum verdict when the final word is accepted and holds it
// until the next start of message.
// Assumes: final-slot acceptance on the same cycle as som takes priority.
module msg_cs_verdict
    import msg_cs_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              som,
    input  logic              acpt,
    input  logic              is_last,
    input  logic              en_cur,
    input  logic              tx_mode,
    input  logic              ill_cur,
    input  logic [WORD_W-1:0] acc_final,
    output verdict_t          verdict
);

    verdict_t next_v;
    logic     zero_sum;

    // Form the verdict of a closing word.
    always_comb begin
        zero_sum    = (acc_final == '0);
        next_v.vld  = en_cur;
        next_v.good = en_cur && !tx_mode && zero_sum;
        next_v.rej  = en_cur && !tx_mode && ill_cur && !zero_sum;
    end

    // Capture on the final word, clear on start, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict <= '0;
        end else if (acpt && is_last) begin
            verdict <= next_v;
        end else if (som) begin
            verdict <= '0;
        end
    end

endmodule

// File: rtl/msg_checksum_unit.sv
// Module: msg_checksum_unit (top)
// Message checksum generator and checker: substitutes the checksum into the
// final slot on transmit, checks it on receive and flags rejection.
// Assumes: controls are stable at som; words carry index and total.
module msg_checksum_unit
    import msg_cs_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int IDX_W  = 5,
    localparam int CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              som,
    input  logic              eom,
    input  logic              dir_tx,
    input  logic              chk_en_n,
    input  logic              illeg_tie,
    input  logic              wd_stb,
    input  logic [WORD_W-1:0] wd_data,
    input  logic [IDX_W-1:0]  wd_idx,
    input  logic [CNT_W-1:0]  wd_total,
    output logic [WORD_W-1:0] tx_word,
    output logic              verdict_vld,
    output logic              sum_good,
    output logic              reject_data
);

    logic              acpt;
    logic              is_last;
    logic              en_cur;
    logic              tx_mode;
    logic              ill_cur;
    logic [WORD_W-1:0] acc_base;
    logic [WORD_W-1:0] acc_final;
    verdict_t          verdict;

    msg_cs_frame #(.IDX_W(IDX_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .som      (som),
        .eom      (eom),
        .dir_tx   (dir_tx),
        .chk_en_n (chk_en_n),
        .illeg_tie(illeg_tie),
        .wd_stb   (wd_stb),
        .wd_idx   (wd_idx),
        .wd_total (wd_total),
        .acpt     (acpt),
        .is_last  (is_last),
        .en_cur   (en_cur),
        .tx_mode  (tx_mode),
        .ill_cur  (ill_cur)
    );

    msg_cs_slot #(.WORD_W(WORD_W)) u_slot (
        .en_cur  (en_cur),
        .tx_mode (tx_mode),
        .acpt    (acpt),
        .is_last (is_last),
        .wd_data (wd_data),
        .acc_base(acc_base),
        .tx_word (tx_word)
    );

    msg_cs_accum #(.WORD_W(WORD_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (som),
        .acpt     (acpt),
        .word_eff (tx_word),
        .acc_base (acc_base),
        .acc_final(acc_final)
    );

    msg_cs_verdict #(.WORD_W(WORD_W)) u_verdict (
        .clk      (clk),
        .rst_n    (rst_n),
        .som      (som),
        .acpt     (acpt),
        .is_last  (is_last),
        .en_cur   (en_cur),
        .tx_mode  (tx_mode),
        .ill_cur  (ill_cur),
        .acc_final(acc_final),
        .verdict  (verdict)
    );

    // Drive the flag outputs from the held verdict.
    always_comb begin
        verdict_vld = verdict.vld;
        sum_good    = verdict.good;
        reject_data = verdict.rej;
    end

endmodule

// File: rtl/msg_checksum_chk.sv
// Module: msg_checksum_chk
// Assertion checker for msg_checksum_unit, attached by bind.
// Assumes: observes top-level ports only.
module msg_checksum_chk #(
    parameter int WORD_W = 16,
    parameter int IDX_W  = 5,
    localparam int CNT_W = IDX_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              som,
    input logic              dir_tx,
    input logic              chk_en_n,
    input logic              wd_stb,
    input logic [WORD_W-1:0] wd_data,
    input logic [IDX_W-1:0]  wd_idx,
    input logic [CNT_W-1:0]  wd_total,
    input logic [WORD_W-1:0] tx_word,
    input logic              verdict_vld,
    input logic              sum_good,
    input logic              reject_data
);

    // R9
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!verdict_vld && !sum_good && !reject_data));

    // R5
    reject_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reject_data |-> (verdict_vld && !sum_good));

    // R4
    good_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sum_good |-> verdict_vld);

    // R4
    verdict_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(verdict_vld) |-> $past(wd_stb));

    // R10
    som_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (som && !wd_stb) |=> !verdict_vld);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!som && !wd_stb) |=> $stable({verdict_vld, sum_good, reject_data}));

    // R1
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (som && chk_en_n) |-> (tx_word == wd_data));

    // R6
    one_word_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (som && wd_stb && !chk_en_n && dir_tx && wd_idx == '0 && wd_total == CNT_W'(1))
        |-> (tx_word == '0));

endmodule

bind msg_checksum_unit msg_checksum_chk #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .som        (som),
    .dir_tx     (dir_tx),
    .chk_en_n   (chk_en_n),
    .wd_stb     (wd_stb),
    .wd_data    (wd_data),
    .wd_idx     (wd_idx),
    .wd_total   (wd_total),
    .tx_word    (tx_word),
    .verdict_vld(verdict_vld),
    .sum_good   (sum_good),
    .reject_data(reject_data)
);

// File: tb/msg_checksum_unit_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected items, the monitor pops and compares.
module msg_checksum_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        som = 1'b0, eom = 1'b0, dir_tx = 1'b0, chk_en_n = 1'b1, illeg_tie = 1'b0;
    logic        wd_stb = 1'b0;
    logic [15:0] wd_data = '0;
    logic [4:0]  wd_idx = '0;
    logic [5:0]  wd_total = '0;
    logic [15:0] tx_word;
    logic        verdict_vld, sum_good, reject_data;
    logic        vchk = 1'b0;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        bit          is_verd;
        logic [15:0] w;
        bit          v, g, r;
        string       req;
    } item_t;

    item_t       sb[$];
    logic [15:0] wbuf [0:31];

    always #4 clk = ~clk;

    msg_checksum_unit u_msg_checksum_unit (
        .clk(clk), .rst_n(rst_n), .som(som), .eom(eom), .dir_tx(dir_tx),
        .chk_en_n(chk_en_n), .illeg_tie(illeg_tie), .wd_stb(wd_stb),
        .wd_data(wd_data), .wd_idx(wd_idx), .wd_total(wd_total),
        .tx_word(tx_word), .verdict_vld(verdict_vld), .sum_good(sum_good),
        .reject_data(reject_data)
    );

    function automatic logic [15:0] step(input logic [15:0] acc, input logic [15:0] w);
        logic [15:0] s;
        s = acc + w;
        return {s[14:0], s[15]};
    endfunction

    // Fill wbuf[n-1] so that the first n words close the sum to zero (R2).
    task automatic seal(input int n);
        logic [15:0] a;
        a = '0;
        for (int i = 0; i < n - 1; i++) a = step(a, wbuf[i]);
        wbuf[n-1] = '0 - a;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Send one message: n words of wbuf, declared total; abort sends eom after.
    task automatic send(input bit tx, input bit en_n, input bit ill, input int n,
                        input int total, input bit abort, input string req);
        logic [15:0] acc, e;
        bit          closed;
        item_t       it;
        acc = '0; closed = 0;
        som = 1; dir_tx = tx; chk_en_n = en_n; illeg_tie = ill;
        tick();
        som = 0;
        for (int i = 0; i < n; i++) begin
            e = wbuf[i];
            if (!en_n && tx && i == total - 1) e = '0 - acc;
            acc = step(acc, e);
            if (i == total - 1) closed = 1;
            it = '{is_verd: 0, w: e, v: 0, g: 0, r: 0, req: req};
            sb.push_back(it);
            wd_stb = 1; wd_idx = 5'(i); wd_total = 6'(total); wd_data = wbuf[i];
            tick();
        end
        wd_stb = 0;
        if (abort) begin
            eom = 1; tick(); eom = 0;
        end
        it = '{is_verd: 1, w: '0, v: 0, g: 0, r: 0, req: req};
        if (closed && !en_n) begin
            it.v = 1;
            it.g = !tx && (acc == 16'h0);
            it.r = !tx && ill && (acc != 16'h0);
        end
        sb.push_back(it);
        vchk = 1; tick(); vchk = 0;
    endtask

    // Stray words outside a message, then recheck the held verdict (R7).
    task automatic stray(input bit v, input bit g, input bit r);
        item_t it;
        for (int i = 0; i < 2; i++) begin
            it = '{is_verd: 0, w: 16'h5A5A, v: 0, g: 0, r: 0, req: "R7"};
            sb.push_back(it);
            wd_stb = 1; wd_idx = 5'd2; wd_total = 6'd3; wd_data = 16'h5A5A;
            tick();
        end
        wd_stb = 0;
        it = '{is_verd: 1, w: '0, v: v, g: g, r: r, req: "R7"};
        sb.push_back(it);
        vchk = 1; tick(); vchk = 0;
    endtask

    // Bare start strobe clears the flags (R10).
    task automatic bare_som();
        item_t it;
        som = 1; dir_tx = 0; chk_en_n = 0; illeg_tie = 0;
        tick();
        som = 0;
        it = '{is_verd: 1, w: '0, v: 0, g: 0, r: 0, req: "R10"};
        sb.push_back(it);
        vchk = 1; tick(); vchk = 0;
    endtask

    // Monitor: pop and compare away from the active edge.
    always @(negedge clk) begin
        item_t it;
        if (rst_n && (wd_stb || vchk)) begin
            if (sb.size() == 0) begin
                fails++; checks++;
                $display("FAIL scoreboard empty: actual item none expected item present");
            end else if (wd_stb) begin
                it = sb.pop_front();
                checks++;
                if (it.is_verd || tx_word !== it.w) begin
                    fails++;
                    $display("FAIL %s tx_word actual %h expected %h", it.req, tx_word, it.w);
                end
            end else begin
                it = sb.pop_front();
                checks++;
                if (!it.is_verd || {verdict_vld, sum_good, reject_data} !== {it.v, it.g, it.r}) begin
                    fails++;
                    $display("FAIL %s flags vld/good/rej actual %b%b%b expected %b%b%b",
                             it.req, verdict_vld, sum_good, reject_data, it.v, it.g, it.r);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        @(negedge clk);
        checks++;
        // R9: flags low while in reset
        if ({verdict_vld, sum_good, reject_data} !== 3'b000) begin
            fails++;
            $display("FAIL R9 flags actual %b%b%b expected 000", verdict_vld, sum_good, reject_data);
        end
        tick();
        rst_n = 1;
        tick();

        // R4 / R2: receive, correct checksum
        wbuf[0] = 16'h1234; wbuf[1] = 16'h00FF; wbuf[2] = 16'hBEEF; seal(4);
        send(0, 0, 0, 4, 4, 0, "R4");
        // R7: stray final-slot words do not touch the held pass verdict
        stray(1, 1, 0);
        // R10: bare start clears
        bare_som();
        // R4: receive, bad checksum, no reject
        wbuf[3] = wbuf[3] ^ 16'h0001;
        send(0, 0, 0, 4, 4, 0, "R4");
        // R5: bad checksum with reject control
        send(0, 0, 1, 4, 4, 0, "R5");
        // R5: good checksum with reject control -> no reject
        seal(4);
        send(0, 0, 1, 4, 4, 0, "R5");
        // R3: transmit substitutes final slot
        wbuf[0] = 16'h8001; wbuf[1] = 16'hFFFF; wbuf[2] = 16'h7777; wbuf[3] = 16'hDEAD;
        wbuf[4] = 16'h0F0F;
        send(1, 0, 1, 5, 5, 0, "R3");
        // R1: disabled transmit and receive pass through with no verdict
        send(1, 1, 0, 5, 5, 0, "R1");
        send(0, 1, 1, 5, 5, 0, "R1");
        // R6: one-word messages
        wbuf[0] = 16'h0000; send(0, 0, 1, 1, 1, 0, "R6");
        wbuf[0] = 16'h0005; send(0, 0, 1, 1, 1, 0, "R6");
        wbuf[0] = 16'hABCD; send(1, 0, 0, 1, 1, 0, "R6");
        // R8: early end, no verdict, then stray words stay ignored
        wbuf[0] = 16'h1111; wbuf[1] = 16'h2222;
        send(0, 0, 1, 2, 4, 1, "R8");
        stray(0, 0, 0);
        // R2: longest message, receive then transmit
        for (int i = 0; i < 31; i++) wbuf[i] = 16'(i * 16'h1357 + 16'h0101);
        seal(32);
        send(0, 0, 1, 32, 32, 0, "R2");
        send(1, 0, 0, 32, 32, 0, "R3");

        repeat (2) tick();
        if (sb.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard leftover actual %0d expected 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule